// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesiser loop. It divides an RF-derived clock by a programmable ratio N = 16·M + A. A 13-bit main counter M and a 4-bit swallow counter A steer a 16/17 dual-modulus prescaler, which is modelled here as synchronous logic. The prescaler divides by 17 for the first A of its cycles in each output period and by 16 for the remaining M − A cycles.

An optional divide-by-two stage can be placed in front of the prescaler, which doubles the whole ratio. It is selected by a static enable pin. The block emits a one-clock pulse at the end of every completed division, and a square wave at half that rate.

A new ratio word is captured by a load strobe. It is applied only when the current division finishes, so a retune never produces a short or long output period. The block has no data stream. All pins are plain control and status levels or pulses, so no valid/ready handshake or back-pressure applies.

Top module: `dmod_fb_divider`

## Requirements
- R1: With `prediv_en_i` = 0, the spacing between consecutive `fpd_o` pulses is exactly N input clocks. Here M = ratio[16:4], A = ratio[3:0] and N = 16·M + A, for any legal ratio word in 240..131071 (M ≥ 15, which guarantees M ≥ A).
- R2: With `prediv_en_i` = 1, held static since reset, the pulse spacing is exactly 2·N input clocks.
- R3: `fpd_o` is high for exactly one clock per completed division.
- R4: `fpd_half_o` is 0 after reset. It inverts exactly once per `fpd_o` pulse, one clock after the pulse, and holds otherwise.
- R5: A ratio word presented with `load_i` high is captured. The division already in progress completes with the old ratio, and the new ratio governs every period after that boundary.
- R6: Changes on `ratio_i` while `load_i` is low have no effect on the pulse spacing.
- R7: During reset, `fpd_o` and `fpd_half_o` are 0. After reset the active ratio is 240 until a load occurs.
- R8: Within each period the prescaler runs A cycles of 17 followed by M − A cycles of 16. Its modulus changes only at a prescaler cycle boundary, and its count never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RF-derived input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prediv_en_i | input | 1 | Static enable of the front divide-by-two stage |
| load_i | input | 1 | Strobe that captures `ratio_i` |
| ratio_i | input | 17 | Ratio word: M in bits 16:4, A in bits 3:0 |
| fpd_o | output | 1 | One-clock pulse per completed division |
| fpd_half_o | output | 1 | Toggles on every `fpd_o` pulse |

## Verification
The assertions check, on every cycle, the following:
- the single-cycle width of `fpd_o` and the one-toggle-per-pulse behaviour of `fpd_half_o`;
- the alternate-cycle tick of the divide-by-two stage;
- the prescaler count bound, and that its modulus changes only at a prescaler boundary;
- that the swallow count never exceeds the main count;
- that the main counter is reloaded only when a prescaler cycle completes.

Only the bench's scenarios can show the following:
- that the exact number of input clocks between pulses matches 16·M + A, or twice that;
- that a load made mid-period lands at the next boundary and not before;
- that an unstrobed ratio change is ignored.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  // Width of the main (M) counter and the swallow (A) counter.
  localparam int unsigned M_W_DEF   = 13;
  localparam int unsigned A_W_DEF   = 4;
  localparam int unsigned RATIO_DEF = 240;

  // Number of prescaler cycles in one period: the upper field of the word.
  function automatic int unsigned main_field(input int unsigned word, input int unsigned a_w);
    return word >> a_w;
  endfunction

  // Number of cycles at the high modulus: the lower field of the word.
  function automatic int unsigned swallow_field(input int unsigned word, input int unsigned a_w);
    return word % (1 << a_w);
  endfunction
endpackage

// File: rtl/dmd_prediv.sv
// Optional front divide-by-two, realised as a clock-enable tick.
module dmd_prediv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   phase_q <= 1'b0;
    else if (en_i) phase_q <= ~phase_q;
    else           phase_q <= 1'b0;
  end

  assign tick_o = en_i ? phase_q : 1'b1;

  // R2: with the stage enabled, ticks never come on consecutive clocks.
  p_half_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> !tick_o);

  // R2: with the stage enabled, a missing tick is followed by one.
  p_no_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !tick_o) |=> tick_o);
endmodule

// File: rtl/dmd_prescaler.sv
// Dual-modulus prescaler: divides ticks by 2**CW or 2**CW + 1.
module dmd_prescaler #(
  parameter int unsigned CW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mod_hi_i,
  output logic wrap_o
);
  localparam int unsigned BASE = 1 << CW;
  localparam logic [CW:0] LAST_HI = (CW+1)'(BASE);
  localparam logic [CW:0] LAST_LO = (CW+1)'(BASE - 1);

  logic [CW:0] cnt_q;
  logic [CW:0] last;

  assign last   = mod_hi_i ? LAST_HI : LAST_LO;
  assign wrap_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // R8: the count never runs past the high-modulus end value.
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_HI);

  // R8: the modulus select moves only right after a prescaler cycle ends.
  p_mod_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_hi_i) |-> $past(wrap_o));

  // R8: every prescaler cycle starts from a zero count.
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/dmd_mod_ctrl.sv
// Main and swallow counters, plus the shadow register for the ratio word.
module dmd_mod_ctrl #(
  parameter int unsigned M_W       = dmd_pkg::M_W_DEF,
  parameter int unsigned A_W       = dmd_pkg::A_W_DEF,
  parameter int unsigned RST_RATIO = dmd_pkg::RATIO_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             load_i,
  input  logic [M_W+A_W-1:0] ratio_i,
  output logic             mod_hi_o,
  output logic             end_o
);
  localparam int unsigned RW = M_W + A_W;
  localparam logic [M_W-1:0] RST_M = M_W'(dmd_pkg::main_field(RST_RATIO, A_W));
  localparam logic [A_W-1:0] RST_A = A_W'(dmd_pkg::swallow_field(RST_RATIO, A_W));

  logic [RW-1:0]  shadow_q;
  logic [RW-1:0]  next_word;
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;

  // A load coinciding with a boundary applies at that boundary.
  assign next_word = load_i ? ratio_i : shadow_q;
  assign mod_hi_o  = (a_q != '0);
  assign end_o     = wrap_i && (m_q == M_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     shadow_q <= {RST_M, RST_A};
    else if (load_i) shadow_q <= ratio_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      m_q <= RST_M;
      a_q <= RST_A;
    end else if (wrap_i) begin
      if (m_q == M_W'(1)) begin
        m_q <= next_word[RW-1:A_W];
        a_q <= next_word[A_W-1:0];
      end else begin
        m_q <= m_q - 1'b1;
        if (a_q != '0) a_q <= a_q - 1'b1;
      end
    end
  end

  // R8: the swallowed cycles never outnumber the remaining main cycles.
  p_a_le_m_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_q <= A_W'(m_q > M_W'((1 << A_W) - 1) ? ((1 << A_W) - 1) : m_q));

  // R1: the main counter never stalls at zero.
  p_m_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_q != '0);

  // R5: the counters change only when a prescaler cycle has completed.
  p_boundary_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(m_q) || !$stable(a_q)) |-> $past(wrap_i));

  // R6: the captured word holds while no load is strobed.
  p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_q));
endmodule

// File: rtl/dmod_fb_divider.sv
module dmod_fb_divider #(
  parameter int unsigned M_W       = dmd_pkg::M_W_DEF,
  parameter int unsigned A_W       = dmd_pkg::A_W_DEF,
  parameter int unsigned RST_RATIO = dmd_pkg::RATIO_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prediv_en_i,
  input  logic               load_i,
  input  logic [M_W+A_W-1:0] ratio_i,
  output logic               fpd_o,
  output logic               fpd_half_o
);
  logic tick;
  logic wrap;
  logic mod_hi;
  logic div_end;
  logic fpd_q;
  logic half_q;

  dmd_prediv u_prediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (prediv_en_i),
    .tick_o (tick)
  );

  dmd_prescaler #(.CW(A_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mod_hi_i (mod_hi),
    .wrap_o   (wrap)
  );

  dmd_mod_ctrl #(.M_W(M_W), .A_W(A_W), .RST_RATIO(RST_RATIO)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .load_i   (load_i),
    .ratio_i  (ratio_i),
    .mod_hi_o (mod_hi),
    .end_o    (div_end)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fpd_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      fpd_q  <= div_end;
      half_q <= half_q ^ fpd_q;
    end
  end

  assign fpd_o      = fpd_q;
  assign fpd_half_o = half_q;

  // R3: the divided pulse lasts one clock.
  p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |=> !fpd_o);

  // R4: each pulse inverts the half-rate output on the next clock.
  p_half_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |=> (fpd_half_o != $past(fpd_half_o)));

  // R4: without a pulse the half-rate output holds.
  p_half_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpd_o |=> $stable(fpd_half_o));
endmodule

// File: tb/dmod_fb_divider_tb_top.sv
module dmod_fb_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_en = 1'b0;
  logic        load = 1'b0;
  logic [16:0] ratio = '0;
  logic        fpd;
  logic        half;
  int          errors = 0;
  int          checks = 0;
  int          k = 1;

  always #5 clk = ~clk;

  dmod_fb_divider dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .prediv_en_i (pre_en),
    .load_i      (load),
    .ratio_i     (ratio),
    .fpd_o       (fpd),
    .fpd_half_o  (half)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until fpd is seen, then checks the pulse shape (consumes one cycle).
  task automatic measure(input int start, output int cyc);
    logic h;
    cyc = start;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fpd);
    h = half;
    @(negedge clk);
    chk(fpd == 1'b0, "R3 pulse width", int'(fpd), 0);
    chk(half == ~h, "R4 half toggle", int'(half), int'(~h));
  endtask

  // Load mid-period; the old period must finish, then the new one applies.
  task automatic retune(input int old_n, input int new_n, input string req);
    int c;
    measure(1, c);
    repeat (98) @(negedge clk);
    ratio = 17'(new_n);
    load  = 1'b1;
    @(negedge clk);
    load  = 1'b0;
    measure(100, c);
    chk(c == old_n * k, "R5 old ratio completes", c, old_n * k);
    measure(1, c);
    chk(c == new_n * k, req, c, new_n * k);
    measure(1, c);
    chk(c == new_n * k, req, c, new_n * k);
  endtask

  task automatic do_reset(input bit pe);
    rst_n  = 1'b0;
    pre_en = pe;
    k      = pe ? 2 : 1;
    repeat (4) @(negedge clk);
    chk(fpd == 1'b0, "R7 reset fpd", int'(fpd), 0);
    chk(half == 1'b0, "R7 reset half", int'(half), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int c;
    // Divide-by-two front stage enabled.
    do_reset(1'b1);
    measure(0, c);
    measure(1, c);
    chk(c == 240 * 2, "R7 R2 reset ratio", c, 480);
    retune(240, 300, "R2 doubled ratio 300");
    retune(300, 257, "R2 doubled ratio 257");

    // Direct path.
    do_reset(1'b0);
    measure(0, c);
    measure(1, c);
    chk(c == 240, "R7 R1 reset ratio", c, 240);
    retune(240, 255, "R8 R1 ratio 255 (M=15 A=15)");
    retune(255, 256, "R8 R1 ratio 256 (M=16 A=0)");
    retune(256, 4097, "R1 ratio 4097");
    retune(4097, 1000, "R1 ratio 1000");

    // Unstrobed word changes are ignored.
    ratio = 17'd300;
    measure(1, c);
    chk(c == 1000, "R6 ignored without load", c, 1000);
    ratio = 17'd77777;
    measure(1, c);
    chk(c == 1000, "R6 ignored without load", c, 1000);

    // Smallest then largest legal ratio.
    retune(1000, 240, "R1 minimum ratio 240");
    retune(240, 131071, "R1 maximum ratio 131071");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (600000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule